// File: doc/BRIEF.md
# System Clock Source Selector with Hardware Fallback

The block picks which of three clock sources feeds the system clock: an on-chip oscillator, an off-chip crystal oscillator, or a PLL output. Software requests a source by writing a 2-bit code. The block switches to that source only once the source reports ready. It passes through a one-cycle dead period in which no source is selected, so that the downstream clock mux never has two inputs enabled at the same time.

Hardware can take the choice away from software. When the chip comes back from a low-power state, the requested code is forced to the on-chip oscillator. When the clock supervision logic reports that the crystal oscillator has died, the code is also forced to the on-chip oscillator. The second case applies only while supervision is enabled, and it does not matter whether the crystal drives the system clock directly or through the PLL. The code 11 is illegal: it is never accepted from software and never becomes the requested or active source.

Top module: `clksw_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the requested code and the status are 00 and the mux select is 001.
- R2: A software write of 00 (on-chip), 01 (crystal) or 10 (PLL) appears on the requested code one clock later, unless a hardware force occurs in the same cycle.
- R3: A software write of 11 is discarded, and the requested code keeps its previous value.
- R4: A low-power exit pulse sets the requested code to 00 one clock later, and it wins over a software write in the same cycle.
- R5: A crystal failure pulse with supervision enabled sets the requested code to 00 one clock later, and it wins over a software write in the same cycle.
- R6: A crystal failure pulse with supervision disabled has no effect on the requested code.
- R7: The status (code of the source in use) moves to the requested code only after that source's ready bit (bit 0 on-chip, bit 1 crystal, bit 2 PLL) is high. It stays unchanged while the requested source is not ready.
- R8: The mux select has at most one bit set. While running, it is the one-hot form of the status, with bit index equal to the code. Every change of source passes through exactly one cycle in which the select is 000.
- R9: Neither the requested code nor the status is ever 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_wr_en | input | 1 | Software write strobe for the select code |
| sw_wr_code | input | 2 | Source code written by software |
| lp_exit | input | 1 | One-cycle pulse on exit from a low-power state |
| osc_fail | input | 1 | One-cycle pulse reporting crystal oscillator failure |
| guard_en | input | 1 | Clock supervision enable |
| src_rdy | input | 3 | Ready bits of on-chip, crystal and PLL sources |
| sel_code | output | 2 | Requested source code |
| sel_stat | output | 2 | Code of the source actually in use |
| mux_sel | output | 3 | Registered one-hot select for the clock mux |

## Verification
The bench targets a write of 11, which a careless decoder would pass through as an illegal active source. It also drives a force and a software write in the same cycle, where reversed priority would leave the crystal or PLL selected after a failure. A failure pulse with supervision off must change nothing, while a design that ignores the enable would fall back anyway. Requests to sources whose ready bit stays low must stall the status. A sequencer that skips the dead cycle, or switches without ready, shows up as a wrong status or a mux select mismatch in the affected cycle.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int N_SRC = 3;
  localparam int SEL_W = $clog2(N_SRC + 1);

  typedef enum logic [SEL_W-1:0] {
    SRC_INT = 2'b00,
    SRC_EXT = 2'b01,
    SRC_PLL = 2'b10,
    SRC_BAD = 2'b11
  } src_e;

  // one-hot decode of a source code; the illegal code maps to all zeros
  function automatic logic [N_SRC-1:0] src_onehot(input logic [SEL_W-1:0] code);
    logic [N_SRC-1:0] r;
    r = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (code == SEL_W'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/clksw_rstsync.sv
module clksw_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clksw_req.sv
module clksw_req
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_code,
  input  logic             force_int,
  output logic [SEL_W-1:0] req_q
);
  logic             wr_ok;
  logic             upd_en;
  logic [SEL_W-1:0] req_d;

  always_comb begin
    wr_ok  = wr_en && (wr_code != SRC_BAD);
    upd_en = force_int || wr_ok;
    if (force_int) req_d = SRC_INT;
    else           req_d = wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= SRC_INT;
    else if (upd_en) req_q <= req_d;
  end
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] req,
  input  logic [N_SRC-1:0] src_rdy,
  output logic [SEL_W-1:0] cur_q,
  output logic [N_SRC-1:0] mux_q
);
  logic             gap_q, gap_d;
  logic [SEL_W-1:0] tgt_q, tgt_d, cur_d;
  logic             tgt_ready, start;

  always_comb begin
    tgt_ready = |(src_onehot(req) & src_rdy);
    start     = !gap_q && (req != cur_q) && tgt_ready;
    gap_d     = gap_q;
    tgt_d     = tgt_q;
    cur_d     = cur_q;
    if (gap_q) begin
      cur_d = tgt_q;
      gap_d = 1'b0;
    end else if (start) begin
      tgt_d = req;
      gap_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 1'b0;
      tgt_q <= SRC_INT;
      cur_q <= SRC_INT;
      mux_q <= src_onehot(SRC_INT);
    end else begin
      gap_q <= gap_d;
      if (start) tgt_q <= tgt_d;
      if (gap_q) cur_q <= cur_d;
      mux_q <= gap_d ? '0 : src_onehot(cur_d);
    end
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [1:0]       sw_wr_code,
  input  logic             lp_exit,
  input  logic             osc_fail,
  input  logic             guard_en,
  input  logic [2:0]       src_rdy,
  output logic [1:0]       sel_code,
  output logic [1:0]       sel_stat,
  output logic [2:0]       mux_sel
);
  logic rst_q;
  logic force_int;

  assign force_int = lp_exit || (osc_fail && guard_en);

  clksw_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  clksw_req u_req (
    .clk       (clk),
    .rst_n     (rst_q),
    .wr_en     (sw_wr_en),
    .wr_code   (sw_wr_code),
    .force_int (force_int),
    .req_q     (sel_code)
  );

  clksw_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .req     (sel_code),
    .src_rdy (src_rdy),
    .cur_q   (sel_stat),
    .mux_q   (mux_sel)
  );
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk
  import clksw_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sw_wr_en,
  input logic [1:0] sw_wr_code,
  input logic       lp_exit,
  input logic       osc_fail,
  input logic       guard_en,
  input logic [1:0] sel_code,
  input logic [1:0] sel_stat,
  input logic [2:0] mux_sel
);
  // R9
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code != SRC_BAD) && (sel_stat != SRC_BAD));

  // R3
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && sw_wr_code == SRC_BAD && !lp_exit && !(osc_fail && guard_en))
      |=> $stable(sel_code));

  // R4
  lp_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit |=> (sel_code == SRC_INT));

  // R5
  fail_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_fail && guard_en) |=> (sel_code == SRC_INT));

  // R8
  mux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mux_sel));

  // R8
  mux_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != 3'b000) |-> (mux_sel == src_onehot(sel_stat)));

  // R7
  stat_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stat != $past(sel_stat)) |-> ($past(mux_sel) == 3'b000));
endmodule

bind clksw_ctrl clksw_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .sw_wr_en   (sw_wr_en),
  .sw_wr_code (sw_wr_code),
  .lp_exit    (lp_exit),
  .osc_fail   (osc_fail),
  .guard_en   (guard_en),
  .sel_code   (sel_code),
  .sel_stat   (sel_stat),
  .mux_sel    (mux_sel)
);

// File: tb/clksw_ctrl_tb_top.sv
module clksw_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int N_RAND = 3000;

  logic       clk;
  logic       rst_n;
  logic       sw_wr_en;
  logic [1:0] sw_wr_code;
  logic       lp_exit;
  logic       osc_fail;
  logic       guard_en;
  logic [2:0] src_rdy;
  logic [1:0] sel_code;
  logic [1:0] sel_stat;
  logic [2:0] mux_sel;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  // reference state derived from the requirements
  logic [1:0] m_req, m_stat, m_tgt;
  logic       m_gap;
  string      req_tag;

  clksw_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_code(sw_wr_code),
    .lp_exit(lp_exit), .osc_fail(osc_fail), .guard_en(guard_en),
    .src_rdy(src_rdy), .sel_code(sel_code), .sel_stat(sel_stat), .mux_sel(mux_sel)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [2:0] exp_onehot(input logic [1:0] c);
    case (c)
      2'b00:   return 3'b001;
      2'b01:   return 3'b010;
      2'b10:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic frc;
    frc = lp_exit || (osc_fail && guard_en);
    if (m_gap) begin
      m_stat = m_tgt;
      m_gap  = 1'b0;
    end else if (m_req != m_stat && src_rdy[m_req]) begin
      m_tgt = m_req;
      m_gap = 1'b1;
    end
    if (lp_exit)                       req_tag = "R4";
    else if (osc_fail && guard_en)     req_tag = "R5";
    else if (osc_fail)                 req_tag = "R6";
    else if (sw_wr_en && sw_wr_code == 2'b11) req_tag = "R3";
    else                               req_tag = "R2";
    if (frc) m_req = 2'b00;
    else if (sw_wr_en && sw_wr_code != 2'b11) m_req = sw_wr_code;
  endtask

  task automatic compare();
    logic [2:0] m_mux;
    m_mux = m_gap ? 3'b000 : exp_onehot(m_stat);
    check(sel_code == m_req, req_tag, {1'b0, sel_code}, {1'b0, m_req});
    check(sel_stat == m_stat, "R7", {1'b0, sel_stat}, {1'b0, m_stat});
    check(mux_sel == m_mux, "R8", mux_sel, m_mux);
    check(sel_code != 2'b11 && sel_stat != 2'b11, "R9", {1'b0, sel_stat}, 3'b000);
  endtask

  // called at a falling edge: drive, let one rising edge pass, then compare
  task automatic step(input logic we, input logic [1:0] wc, input logic lp,
                      input logic fl, input logic ge, input logic [2:0] rdy);
    sw_wr_en = we; sw_wr_code = wc; lp_exit = lp;
    osc_fail = fl; guard_en = ge; src_rdy = rdy;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; sw_wr_en = 1'b0; sw_wr_code = 2'b00; lp_exit = 1'b0;
    osc_fail = 1'b0; guard_en = 1'b0; src_rdy = 3'b111;
    m_req = 2'b00; m_stat = 2'b00; m_tgt = 2'b00; m_gap = 1'b0; req_tag = "R2";
    repeat (3) @(negedge clk);
    // R1 during reset
    check(sel_code == 2'b00, "R1", {1'b0, sel_code}, 3'b000);
    check(sel_stat == 2'b00, "R1", {1'b0, sel_stat}, 3'b000);
    check(mux_sel == 3'b001, "R1", mux_sel, 3'b001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    check(sel_code == 2'b00 && sel_stat == 2'b00 && mux_sel == 3'b001, "R1",
          mux_sel, 3'b001);

    // R2 / R7: request crystal while it is not ready, status must hold
    step(1, 2'b01, 0, 0, 1, 3'b001);
    repeat (5) step(0, 2'b00, 0, 0, 1, 3'b001);
    // ready arrives: gap cycle then switch (R8)
    repeat (4) step(0, 2'b00, 0, 0, 1, 3'b011);
    // R3: illegal write ignored
    step(1, 2'b11, 0, 0, 1, 3'b111);
    step(0, 2'b00, 0, 0, 1, 3'b111);
    // PLL request
    step(1, 2'b10, 0, 0, 1, 3'b111);
    repeat (3) step(0, 2'b00, 0, 0, 1, 3'b111);
    // R6: failure with supervision off changes nothing
    step(0, 2'b00, 0, 1, 0, 3'b111);
    repeat (2) step(0, 2'b00, 0, 0, 0, 3'b111);
    // R5: failure with supervision on beats a simultaneous write
    step(1, 2'b01, 0, 1, 1, 3'b111);
    repeat (3) step(0, 2'b00, 0, 0, 1, 3'b111);
    // R4: low-power exit beats a simultaneous write
    step(1, 2'b10, 0, 0, 1, 3'b111);
    repeat (3) step(0, 2'b00, 0, 0, 1, 3'b111);
    step(1, 2'b01, 1, 0, 0, 3'b111);
    repeat (3) step(0, 2'b00, 0, 0, 1, 3'b111);

    for (int i = 0; i < N_RAND; i++) begin
      logic [2:0] r;
      r[0] = ($urandom % 16) != 0;
      r[1] = ($urandom % 4) != 0;
      r[2] = ($urandom % 4) != 0;
      step(($urandom % 3) == 0, 2'($urandom), ($urandom % 29) == 0,
           ($urandom % 23) == 0, 1'($urandom), r);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule